// File: doc/BRIEF.md
# TDM Dual-Highway Receive Aligner

The block takes a serial time-division-multiplexed stream and turns it into bytes. A frame holds 32 byte-wide time slots. For each slot, a select mask picks which of two serial data lines is sampled. A frame-sync strobe marks the stream origin. The first slot begins a programmable number of whole bytes after that origin, from 0 to 127. An optional double-rate mode lets the bit clock run at twice the data rate.

Each completed byte leaves the block together with its slot number and a one-cycle valid pulse. The configuration is written through a simple write strobe into shadow storage. A frame sync copies the shadow into the active settings, so the settings never change part-way through a frame.

Top module: `tdm_rx_aligner`

## Requirements
- R1: A frame produces exactly 32 bytes, with slot numbers 0 through 31 in ascending order. After slot 31, valid_o stays low until the next frame sync.
- R2: Select mask bit k chooses the input line for slot k. A value of 0 samples pri_i and a value of 1 samples sec_i.
- R3: Reset clears the settings to mask 0, offset 0 and single rate, and holds valid_o low. Until the first frame sync, valid_o stays low whatever the data lines do.
- R4: The byte offset equals cfg_off_lo_i plus 64 times cfg_off_hi_i. That many whole bytes of the stream are discarded before slot 0 begins.
- R5: In single-rate mode, stream bit j (counting from 0) is sampled on the clock edge j+1 edges after the frame-sync edge. Data present on the frame-sync edge itself is ignored.
- R6: With cfg_dbl_i set, each stream bit lasts two clock cycles and is sampled on the second one. Stream bit j is sampled on edge 2j+2 after the frame-sync edge.
- R7: Bits enter MSB first. byte_o and slot_o are updated, and valid_o pulses high for one cycle, on the same edge that samples the eighth bit of the slot. For offset O, slot k and rate factor m (1 in single-rate mode, 2 in double-rate mode), this is edge 8*m*(O+k+1) after frame sync.
- R8: A frame-sync strobe restarts the offset count, the bit count and the slot count, at any point in a frame. The edge that takes the strobe never produces a valid byte, even if it would have completed one.
- R9: A configuration write takes effect only at the next frame sync. A write on the same edge as a frame sync applies to the frame that this sync starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fs_i | input | 1 | Frame-sync strobe |
| pri_i | input | 1 | Primary serial data line |
| sec_i | input | 1 | Secondary serial data line |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 32 | Per-slot line select mask |
| cfg_off_lo_i | input | 6 | Byte offset, low part (0 to 63) |
| cfg_off_hi_i | input | 1 | Adds 64 bytes to the offset |
| cfg_dbl_i | input | 1 | Double-rate mode |
| byte_o | output | 8 | Assembled slot byte |
| slot_o | output | 5 | Slot number of byte_o |
| valid_o | output | 1 | One-cycle strobe for a new byte |

## Verification
Two events can fall on the same edge: a frame sync, and the sample that completes a slot byte. The bench cuts a frame short so that the new strobe lands exactly on the edge that would have produced a byte. It then checks that valid_o stays low on that edge and that the next frame starts again from slot 0. A configuration write can also share an edge with a frame sync. That case is judged by checking that every byte of the frame follows the new mask, offset and rate, while a write made in the middle of a frame leaves that frame's bytes unchanged.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int NUM_SLOTS = 32;
  localparam int BYTE_W    = 8;
  localparam int OFF_LO_W  = 6;
  localparam int OFF_W     = OFF_LO_W + 1;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int BIT_W     = $clog2(BYTE_W);

  typedef struct packed {
    logic [NUM_SLOTS-1:0] sel;
    logic [OFF_W-1:0]     off;
    logic                 dbl;
  } cfg_t;
endpackage

// File: rtl/tdm_rx_cfg.sv
module tdm_rx_cfg
  import tdm_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  cfg_t wr_i,
  input  logic fs_i,
  output cfg_t act_o
);
  cfg_t shadow_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      if (we_i) shadow_q <= wr_i;
      // a write coincident with sync applies to the frame it starts
      if (fs_i) act_q <= we_i ? wr_i : shadow_q;
    end
  end

  assign act_o = act_q;

  assert_hold_until_fs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fs_i |=> $stable(act_q));
endmodule

// File: rtl/tdm_rx_bit_timer.sv
module tdm_rx_bit_timer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fs_i,
  input  logic dbl_i,
  output logic sample_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   phase_q <= 1'b0;
    else if (fs_i) phase_q <= 1'b0;
    else           phase_q <= ~phase_q;
  end

  // double rate: sample on the second cycle of each bit window
  assign sample_o = !fs_i && (!dbl_i || phase_q);

  assert_dbl_spacing_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbl_i && sample_o) |=> !sample_o);
endmodule

// File: rtl/tdm_rx_slot_asm.sv
module tdm_rx_slot_asm
  import tdm_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fs_i,
  input  logic              sample_i,
  input  cfg_t              cfg_i,
  input  logic              pri_i,
  input  logic              sec_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              valid_o
);
  logic              run_q;
  logic [BIT_W-1:0]  bit_q;
  logic [OFF_W-1:0]  skip_q;
  logic [SLOT_W-1:0] slot_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              live, din, last_bit;

  assign live     = run_q && (skip_q == cfg_i.off);
  assign din      = cfg_i.sel[slot_q] ? sec_i : pri_i;
  assign last_bit = (bit_q == BIT_W'(BYTE_W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      bit_q   <= '0;
      skip_q  <= '0;
      slot_q  <= '0;
      shreg_q <= '0;
      byte_o  <= '0;
      slot_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (fs_i) begin
        run_q  <= 1'b1;
        bit_q  <= '0;
        skip_q <= '0;
        slot_q <= '0;
      end else if (sample_i && run_q) begin
        bit_q <= bit_q + BIT_W'(1);
        if (!live) begin
          if (last_bit) skip_q <= skip_q + OFF_W'(1);
        end else begin
          shreg_q <= {shreg_q[BYTE_W-2:0], din};
          if (last_bit) begin
            byte_o  <= {shreg_q[BYTE_W-2:0], din};
            slot_o  <= slot_q;
            valid_o <= 1'b1;
            slot_q  <= slot_q + SLOT_W'(1);
            if (slot_q == SLOT_W'(NUM_SLOTS-1)) run_q <= 1'b0;
          end
        end
      end
    end
  end

  // checker state: slot number expected on the next valid byte
  logic [SLOT_W-1:0] chk_next_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      chk_next_q <= '0;
    else if (fs_i)    chk_next_q <= '0;
    else if (valid_o) chk_next_q <= slot_o + SLOT_W'(1);
  end

  assert_slot_order_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (slot_o == chk_next_q));
  assert_valid_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_no_out_after_fs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_i |=> !valid_o);
endmodule

// File: rtl/tdm_rx_aligner.sv
module tdm_rx_aligner
  import tdm_rx_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fs_i,
  input  logic                 pri_i,
  input  logic                 sec_i,
  input  logic                 cfg_we_i,
  input  logic [NUM_SLOTS-1:0] cfg_sel_i,
  input  logic [OFF_LO_W-1:0]  cfg_off_lo_i,
  input  logic                 cfg_off_hi_i,
  input  logic                 cfg_dbl_i,
  output logic [BYTE_W-1:0]    byte_o,
  output logic [SLOT_W-1:0]    slot_o,
  output logic                 valid_o
);
  cfg_t wr_cfg, act_cfg;
  logic sample;

  assign wr_cfg.sel = cfg_sel_i;
  assign wr_cfg.off = {cfg_off_hi_i, cfg_off_lo_i};
  assign wr_cfg.dbl = cfg_dbl_i;

  tdm_rx_cfg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .wr_i   (wr_cfg),
    .fs_i   (fs_i),
    .act_o  (act_cfg)
  );

  tdm_rx_bit_timer u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fs_i     (fs_i),
    .dbl_i    (act_cfg.dbl),
    .sample_o (sample)
  );

  tdm_rx_slot_asm u_asm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fs_i     (fs_i),
    .sample_i (sample),
    .cfg_i    (act_cfg),
    .pri_i    (pri_i),
    .sec_i    (sec_i),
    .byte_o   (byte_o),
    .slot_o   (slot_o),
    .valid_o  (valid_o)
  );
endmodule

// File: tb/tdm_rx_aligner_bench.sv
module tdm_rx_aligner_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fs_i = 1'b0, pri_i = 1'b0, sec_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_sel_i = '0;
  logic [5:0]  cfg_off_lo_i = '0;
  logic        cfg_off_hi_i = 1'b0, cfg_dbl_i = 1'b0;
  logic [7:0]  byte_o;
  logic [4:0]  slot_o;
  logic        valid_o;

  int vecs = 0;
  int bad  = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  tdm_rx_aligner u_tdm_rx_aligner (
    .clk_i, .rst_ni, .fs_i, .pri_i, .sec_i, .cfg_we_i, .cfg_sel_i,
    .cfg_off_lo_i, .cfg_off_hi_i, .cfg_dbl_i, .byte_o, .slot_o, .valid_o
  );

  function automatic logic [7:0] pbyte(int b, int seed);
    return 8'((b * 29 + seed * 7 + 3) & 255);
  endfunction
  function automatic logic [7:0] sbyte(int b, int seed);
    return 8'(((b * 53 + seed * 11) ^ 8'ha5) & 255);
  endfunction

  task automatic chk(string tag, bit ok, string what, int act, int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic put_cfg(logic [31:0] s, int off, bit dbl);
    cfg_sel_i    = s;
    cfg_off_lo_i = 6'(off & 63);
    cfg_off_hi_i = off[6];
    cfg_dbl_i    = dbl;
  endtask

  // wmode: 0 no write, 1 write one cycle before sync, 2 write with sync
  task automatic frame(string tag, logic [31:0] esel, int eoff, bit edbl, int wmode,
                       int abort_at, int mid_at, logic [31:0] msel, int moff, bit mdbl,
                       int seed);
    int m = edbl ? 2 : 1;
    int nlen;
    if (wmode == 1) begin
      put_cfg(esel, eoff, edbl); cfg_we_i = 1'b1;
      @(negedge clk_i); cfg_we_i = 1'b0;
    end
    if (wmode == 2) begin put_cfg(esel, eoff, edbl); cfg_we_i = 1'b1; end
    fs_i = 1'b1;
    pri_i = 1'b1; sec_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    fs_i = 1'b0; cfg_we_i = 1'b0;
    chk({tag, "/R8 sync edge"}, valid_o == 1'b0, "valid", valid_o, 0);
    nlen = (abort_at > 0) ? abort_at : (eoff + 32) * 8 * m + 40;
    for (int n = 1; n <= nlen; n++) begin
      int p = (n - 1) / m;
      int b = p / 8;
      int i = 7 - (p % 8);
      if (n == mid_at) begin put_cfg(msel, moff, mdbl); cfg_we_i = 1'b1; end
      else cfg_we_i = 1'b0;
      pri_i = pbyte(b, seed)[i];
      sec_i = sbyte(b, seed)[i];
      @(posedge clk_i); @(negedge clk_i);
      begin
        int k = n / (8 * m) - eoff - 1;
        bit ev = (n % (8 * m) == 0) && (k >= 0) && (k < 32);
        if (ev) begin
          logic [7:0] eb = esel[k] ? sbyte(eoff + k, seed) : pbyte(eoff + k, seed);
          chk({tag, "/R7 valid"}, valid_o == 1'b1, "valid", valid_o, 1);
          chk({tag, "/R2 byte"}, byte_o == eb, "byte", byte_o, eb);
          chk({tag, "/R1 slot"}, slot_o == 5'(k), "slot", slot_o, k);
        end else begin
          chk({tag, (k >= 32) ? "/R1 idle" : "/R5 no valid"}, valid_o == 1'b0,
              "valid", valid_o, 0);
        end
      end
    end
    cfg_we_i = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R3 reset", valid_o == 1'b0, "valid", valid_o, 0);
    rst_ni = 1'b1;
    // R3: no output before the first sync, even with active data
    for (int n = 0; n < 40; n++) begin
      pri_i = n[0]; sec_i = n[1];
      @(negedge clk_i);
      chk("R3 pre-sync", valid_o == 1'b0, "valid", valid_o, 0);
    end
    // R3: reset settings, all slots from primary, no offset, single rate
    frame("R3", 32'h0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    frame("R2", 32'hA5A5_0F0F, 0, 0, 1, 0, 0, 0, 0, 0, 2);
    frame("R2", 32'hFFFF_FFFF, 2, 0, 1, 0, 0, 0, 0, 0, 3);
    // R4: offset = low field + 64 * high bit
    frame("R4", 32'h8000_0001, 1, 0, 1, 0, 0, 0, 0, 0, 4);
    frame("R4", 32'h1234_5678, 5, 0, 1, 0, 0, 0, 0, 0, 5);
    frame("R4", 32'hDEAD_BEEF, 63, 0, 1, 0, 0, 0, 0, 0, 6);
    frame("R4", 32'h0F0F_F0F0, 64, 0, 1, 0, 0, 0, 0, 0, 7);
    frame("R4", 32'h5555_AAAA, 65, 0, 1, 0, 0, 0, 0, 0, 8);
    frame("R4", 32'hC3C3_3C3C, 127, 0, 1, 0, 0, 0, 0, 0, 9);
    // R6: double rate
    frame("R6", 32'h0000_FFFF, 0, 1, 1, 0, 0, 0, 0, 0, 10);
    frame("R6", 32'h9696_6969, 3, 1, 1, 0, 0, 0, 0, 0, 11);
    frame("R6", 32'h7777_1111, 64, 1, 1, 0, 0, 0, 0, 0, 12);
    frame("R6", 32'hFFFF_0000, 127, 1, 1, 0, 0, 0, 0, 0, 13);
    // R8: cut short mid-frame, then on the edge that would finish slot 2
    frame("R8", 32'h3333_CCCC, 1, 0, 1, 83, 0, 0, 0, 0, 14);
    frame("R8", 32'h3333_CCCC, 1, 0, 0, 8 * (1 + 3) - 1, 0, 0, 0, 0, 15);
    frame("R8", 32'h3333_CCCC, 1, 0, 0, 0, 0, 0, 0, 0, 16);
    frame("R8", 32'hAAAA_5555, 2, 1, 1, 16 * (2 + 1) - 1, 0, 0, 0, 0, 17);
    frame("R8", 32'hAAAA_5555, 2, 1, 0, 0, 0, 0, 0, 0, 18);
    // R9: mid-frame write waits for the next sync
    frame("R9", 32'h0101_0101, 4, 0, 1, 0, 100, 32'hFEFE_FEFE, 7, 1, 19);
    frame("R9", 32'hFEFE_FEFE, 7, 1, 0, 0, 0, 0, 0, 0, 20);
    // R9: write on the sync edge applies to that frame
    frame("R9", 32'h00FF_FF00, 66, 0, 2, 0, 0, 0, 0, 0, 21);
    frame("R9", 32'h8421_1248, 9, 1, 2, 0, 0, 0, 0, 0, 22);
    done = 1;
    summary();
    $finish;
  end
endmodule